// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block sits between a synchronous host and an asynchronous parallel read-only memory. The memory can return either a 16-bit word or an 8-bit byte per access. The host presents an address, a mode bit (word or byte) and a single-cycle read strobe. The controller latches the request and drives the word-address lines and the width select. It then lowers chip enable and output enable together and waits a fixed number of clock cycles. That count is derived at elaboration from the memory's address, chip-enable and output-enable access limits and its address cycle time. When the count expires the controller captures the data bus and returns the result with a one-cycle valid pulse.

In byte mode the memory reuses its top data pin as the lowest byte-address input. The controller drives the least significant host address bit onto that pin, treats it as an address rather than data, and returns the upper byte lane as zero. Between accesses the memory is put back in standby. A turnaround count covering the memory's output-disable time must pass before the next access can start, so the memory's drivers and the controller's drive on the shared pin never overlap.

All time limits are parameters in nanoseconds. Each is converted to a cycle count by rounding up against the clock period parameter.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs take these values: mem_ce_n=1, mem_oe_n=1, rd_ready=1, rd_valid=0, rd_data=0, mem_addr=0, mem_byte_n=1 and mem_top_oe=0.
- R2: A request is accepted only at a rising edge where rd_req=1 and rd_ready=1. A request made while rd_ready=0 has no effect: the memory pins are unchanged, no extra valid pulse appears and the returned data is unchanged. rd_ready is high only while mem_ce_n=1 and mem_oe_n=1.
- R3: In word mode (rd_byte=0), mem_addr equals rd_addr[22:0], bit 23 is ignored, mem_byte_n=1, mem_top_oe=0, and rd_data equals the full 16-bit bus mem_dq_in[15:0].
- R4: In byte mode (rd_byte=1), mem_addr equals rd_addr[23:1], mem_byte_n=0, mem_top_oe=1 and mem_top_out equals rd_addr[0]. rd_data equals {8'h00, mem_dq_in[7:0]}, whatever the upper lane carries.
- R5: In the cycle after acceptance, mem_ce_n and mem_oe_n both go low. They stay low for ACC_CYC cycles, where ACC_CYC is the largest of ceil(T_ACC/P), ceil(T_CE/P), ceil(T_OE/P) and ceil(T_CYC/P), and P is the clock period. This is 12 cycles at the defaults (90/90/30/90 ns, P=8 ns).
- R6: The bus is captured at the edge that ends that window, and rd_valid is high for exactly that one following cycle, which is ACC_CYC+1 cycles after the accepting edge. At that same edge mem_ce_n and mem_oe_n return high. They stay high for TA_CYC=ceil(T_DIS/P) cycles (3 at the defaults) before rd_ready rises again.
- R7: mem_addr, mem_byte_n, mem_top_oe and mem_top_out change only at an accepting edge, and are held from there until the next acceptance.
- R8: rd_data changes only together with a rd_valid pulse and is held stable between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request strobe |
| rd_byte | input | 1 | 1 = byte access, 0 = word access |
| rd_addr | input | 24 | Byte address (byte mode) or word address in bits 22:0 (word mode) |
| rd_ready | output | 1 | Controller idle, request will be accepted |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a new result |
| rd_data | output | 16 | Read result, upper lane zero in byte mode |
| mem_addr | output | 23 | Memory word-address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_byte_n | output | 1 | Width select, low selects byte mode |
| mem_top_out | output | 1 | Lowest byte-address bit driven onto the top data pin |
| mem_top_oe | output | 1 | Drive enable for the top data pin |
| mem_dq_in | input | 16 | Memory data bus as seen by the controller |

## Verification
The memory pins move one cycle after the accepting edge. rd_valid and rd_data move exactly ACC_CYC+1 cycles after it, and rd_ready returns ACC_CYC+TA_CYC+1 cycles after it. The bench drives inputs on falling edges and counts falling edges from acceptance, checking each of these at the falling edge where it is due and, where the window is bounded, also at the edge before it. Its behavioural memory returns a corrupt pattern whenever any access limit has not elapsed by the sampling instant, and it counts standby gaps shorter than the disable time. A wait count that is one cycle short therefore shows up as a data mismatch.

// File: rtl/prom_rd_pkg.sv
`timescale 1ns/1ps
package prom_rd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ACCESS  = 2'd1,
        SEQ_RECOVER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic byte_mode;
        logic lane_sel;
    } rd_mode_t;

    function automatic int unsigned cyc_ceil(input int unsigned t_ns, input int unsigned p_ns);
        int unsigned c;
        c = (t_ns + p_ns - 1) / p_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        return max2(max2(a, b), max2(c, d));
    endfunction

endpackage

// File: rtl/prom_cycle_timer.sv
`timescale 1ns/1ps
module prom_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/prom_rd_seq.sv
`timescale 1ns/1ps
module prom_rd_seq
    import prom_rd_pkg::*;
#(
    parameter int ACC_CYC = 12,
    parameter int TA_CYC  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    output logic ready,
    output logic accept,
    output logic capture,
    output logic mem_ce_n,
    output logic mem_oe_n
);
    localparam int CNT_W = $clog2(max2(ACC_CYC, TA_CYC) + 1);
    localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);

    seq_state_e state, state_nx;
    logic       t_done;
    logic       t_load;
    logic [CNT_W-1:0] t_val;

    assign ready   = (state == SEQ_IDLE);
    assign accept  = ready && rd_req;
    assign capture = (state == SEQ_ACCESS) && t_done;
    assign t_load  = accept || capture;
    assign t_val   = accept ? ACC_LD : TA_LD;

    prom_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:    if (accept)  state_nx = SEQ_ACCESS;
            SEQ_ACCESS:  if (capture) state_nx = SEQ_RECOVER;
            SEQ_RECOVER: if (t_done)  state_nx = SEQ_IDLE;
            default:                  state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
        end else begin
            state <= state_nx;
            if (accept) begin
                mem_ce_n <= 1'b0;
                mem_oe_n <= 1'b0;
            end else if (capture) begin
                mem_ce_n <= 1'b1;
                mem_oe_n <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/prom_pin_map.sv
`timescale 1ns/1ps
module prom_pin_map
    import prom_rd_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic              req_byte,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_byte_n,
    output logic              mem_top_out,
    output logic              mem_top_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HALF_W = DATA_W / 2;

    rd_mode_t    mode_q;
    logic [DATA_W-1:0] data_nx;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_lane
            if (b < HALF_W) begin : g_low
                assign data_nx[b] = mem_dq_in[b];
            end else begin : g_high
                assign data_nx[b] = mem_dq_in[b] & ~mode_q.byte_mode;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            mem_addr    <= '0;
            mem_byte_n  <= 1'b1;
            mem_top_out <= 1'b0;
            mem_top_oe  <= 1'b0;
        end else if (accept) begin
            mode_q.byte_mode <= req_byte;
            mode_q.lane_sel  <= req_byte & req_addr[0];
            mem_byte_n       <= ~req_byte;
            mem_top_oe       <= req_byte;
            mem_top_out      <= req_byte & req_addr[0];
            mem_addr         <= req_byte ? req_addr[ADDR_W:1] : req_addr[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= data_nx;
        end
    end
endmodule

// File: rtl/prom_rd_ctrl.sv
`timescale 1ns/1ps
module prom_rd_ctrl
    import prom_rd_pkg::*;
#(
    parameter int ADDR_W        = 23,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_ACC_NS      = 90,
    parameter int T_CE_NS       = 90,
    parameter int T_OE_NS       = 30,
    parameter int T_CYC_NS      = 90,
    parameter int T_DIS_NS      = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              rd_byte,
    input  logic [ADDR_W:0]   rd_addr,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_byte_n,
    output logic              mem_top_out,
    output logic              mem_top_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int ACC_CYC = int'(max4(cyc_ceil(T_ACC_NS, CLK_PERIOD_NS),
                                       cyc_ceil(T_CE_NS,  CLK_PERIOD_NS),
                                       cyc_ceil(T_OE_NS,  CLK_PERIOD_NS),
                                       cyc_ceil(T_CYC_NS, CLK_PERIOD_NS)));
    localparam int TA_CYC  = int'(cyc_ceil(T_DIS_NS, CLK_PERIOD_NS));

    logic accept;
    logic capture;

    prom_rd_seq #(.ACC_CYC(ACC_CYC), .TA_CYC(TA_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .ready    (rd_ready),
        .accept   (accept),
        .capture  (capture),
        .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n)
    );

    prom_pin_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .capture     (capture),
        .req_byte    (rd_byte),
        .req_addr    (rd_addr),
        .mem_dq_in   (mem_dq_in),
        .mem_addr    (mem_addr),
        .mem_byte_n  (mem_byte_n),
        .mem_top_out (mem_top_out),
        .mem_top_oe  (mem_top_oe),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/prom_rd_ctrl_chk.sv
`timescale 1ns/1ps
module prom_rd_ctrl_chk #(
    parameter int ADDR_W  = 23,
    parameter int DATA_W  = 16,
    parameter int ACC_CYC = 12,
    parameter int TA_CYC  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_byte_n,
    input logic              mem_top_out,
    input logic              mem_top_oe
);
    logic        ce_q;
    int unsigned low_cnt;
    int unsigned hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q    <= 1'b1;
            low_cnt <= 0;
            hi_cnt  <= TA_CYC;
        end else begin
            ce_q <= mem_ce_n;
            if (!mem_ce_n) begin
                low_cnt <= low_cnt + 1;
                hi_cnt  <= 0;
            end else begin
                low_cnt <= 0;
                if (hi_cnt < 255) hi_cnt <= hi_cnt + 1;
            end
        end
    end

    // R5: enable window lasts exactly ACC_CYC cycles
    p_window_len_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_ce_n && !ce_q) |-> (low_cnt == ACC_CYC));

    // R6: standby gap before a new access covers the disable time
    p_gap_len_r6: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && ce_q) |-> (hi_cnt >= TA_CYC));

    // R6: valid is a single-cycle pulse
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R2: ready only while memory is in standby
    p_ready_standby_r2: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> (mem_ce_n && mem_oe_n));

    // R7: pins held while the access is in progress
    p_pins_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !ce_q) |-> ($stable(mem_addr) && $stable(mem_byte_n) &&
                                  $stable(mem_top_out) && $stable(mem_top_oe)));

    // R4: top pin driven exactly in byte mode during an access
    p_top_drive_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (mem_top_oe == !mem_byte_n));

    // R4: upper lane zero for a byte result
    p_byte_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !mem_byte_n) |-> (rd_data[DATA_W-1:DATA_W/2] == '0));

    // R8: result held between valid pulses
    p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> $stable(rd_data));
endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ACC_CYC(ACC_CYC),
    .TA_CYC (TA_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_ready    (rd_ready),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .mem_addr    (mem_addr),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_byte_n  (mem_byte_n),
    .mem_top_out (mem_top_out),
    .mem_top_oe  (mem_top_oe)
);

// File: tb/test_prom_rd_ctrl.sv
`timescale 1ns/1ps
module test_prom_rd_ctrl;
    localparam int P_NS = 8;
    localparam int ACC  = 12;   // max(ceil(90/8), ceil(90/8), ceil(30/8), ceil(90/8))
    localparam int TA   = 3;    // ceil(20/8)
    localparam int NVEC = 8;

    // [24] = byte mode, [23:0] = address
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 24'h000000},
        {1'b0, 24'hFFFFFF},
        {1'b0, 24'h123456},
        {1'b1, 24'h000000},
        {1'b1, 24'h000001},
        {1'b1, 24'hFFFFFF},
        {1'b1, 24'hABCDEF},
        {1'b0, 24'h2AAAAA}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic        rd_byte = 1'b0;
    logic [23:0] rd_addr = '0;
    logic        rd_ready, rd_valid;
    logic [15:0] rd_data;
    logic [22:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_byte_n, mem_top_out, mem_top_oe;
    logic [15:0] mem_dq = 16'hFFFF;

    int n_cmp = 0;
    int n_bad = 0;
    int n_valid = 0;
    int n_viol = 0;
    int n_reads = 0;
    bit done = 0;

    always #(P_NS/2) clk = ~clk;

    prom_rd_ctrl i_prom_rd_ctrl (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_byte(rd_byte), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_byte_n(mem_byte_n), .mem_top_out(mem_top_out), .mem_top_oe(mem_top_oe),
        .mem_dq_in(mem_dq)
    );

    function automatic logic [15:0] rom_word(input logic [22:0] w);
        return w[15:0] ^ {w[22:16], 9'h000} ^ 16'h5A3C;
    endfunction

    // behavioural memory with access-time tracking
    realtime t_addr = -1000.0, t_ce = -1000.0, t_oe = -1000.0, t_rise = -1000.0;
    always @(mem_addr or mem_top_out or mem_byte_n) t_addr = $realtime;
    always @(posedge mem_ce_n) t_rise = $realtime;
    always @(negedge mem_ce_n) begin
        t_ce = $realtime;
        if (t_ce - t_rise < 20.0) n_viol++;
    end
    always @(negedge mem_oe_n) t_oe = $realtime;

    initial begin
        #0.25;
        forever begin
            realtime now;
            logic [15:0] w;
            now = $realtime;
            w = rom_word(mem_addr);
            if (mem_ce_n !== 1'b0 || mem_oe_n !== 1'b0) begin
                mem_dq = 16'hFFFF;
            end else if (now - t_addr >= 90.0 && now - t_ce >= 90.0 && now - t_oe >= 30.0) begin
                if (mem_byte_n)
                    mem_dq = w;
                else
                    mem_dq = {mem_top_out, 7'h55, (mem_top_out ? w[15:8] : w[7:0])};
            end else begin
                mem_dq = mem_byte_n ? 16'hE1E1 : {mem_top_out, 7'h55, 8'hE1};
            end
            #0.5;
        end
    end

    always @(posedge clk) if (!rst && rd_valid) n_valid++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic bmode, input logic [23:0] a, input bit poke);
        logic [22:0] exp_wa;
        logic [15:0] exp_d;
        logic [15:0] w;
        exp_wa = bmode ? a[23:1] : a[22:0];
        w = rom_word(exp_wa);
        exp_d = bmode ? {8'h00, (a[0] ? w[15:8] : w[7:0])} : w;
        while (!rd_ready) @(negedge clk);
        rd_req = 1'b1; rd_byte = bmode; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0; rd_addr = ~a; rd_byte = ~bmode;
        n_reads++;
        chk(bmode ? "R4 mem_addr" : "R3 mem_addr", 32'(mem_addr), 32'(exp_wa));
        chk(bmode ? "R4 byte_n" : "R3 byte_n", 32'(mem_byte_n), 32'(!bmode));
        chk(bmode ? "R4 top_oe" : "R3 top_oe", 32'(mem_top_oe), 32'(bmode));
        if (bmode) chk("R4 top_out", 32'(mem_top_out), 32'(a[0]));
        chk("R5 enables low", {30'd0, mem_ce_n, mem_oe_n}, 32'd0);
        chk("R2 ready low", 32'(rd_ready), 32'd0);
        for (int i = 2; i <= ACC; i++) begin
            @(negedge clk);
            if (poke && i == 3) begin
                rd_req = 1'b1; rd_byte = ~bmode; rd_addr = a ^ 24'h000301;
            end else if (poke && i == 4) begin
                rd_req = 1'b0;
                chk("R2 addr kept", 32'(mem_addr), 32'(exp_wa));
                chk("R2 mode kept", 32'(mem_byte_n), 32'(!bmode));
            end
        end
        chk("R5 ce low at end", 32'(mem_ce_n), 32'd0);
        chk("R6 valid not early", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R6 valid pulse", 32'(rd_valid), 32'd1);
        chk(bmode ? "R4 data" : "R3 data", 32'(rd_data), 32'(exp_d));
        chk("R6 ce high", {30'd0, mem_ce_n, mem_oe_n}, 32'd3);
        for (int i = 2; i <= TA; i++) @(negedge clk);
        chk("R6 ready still low", 32'(rd_ready), 32'd0);
        chk("R6 valid dropped", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R6 ready back", 32'(rd_ready), 32'd1);
        chk("R8 data held", 32'(rd_data), 32'(exp_d));
        chk("R7 addr held", 32'(mem_addr), 32'(exp_wa));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 ce/oe in reset", {30'd0, mem_ce_n, mem_oe_n}, 32'd3);
        chk("R1 valid/ready in reset", {30'd0, rd_valid, rd_ready}, 32'd1);
        chk("R1 data in reset", 32'(rd_data), 32'd0);
        chk("R1 pins in reset", {7'd0, mem_addr, mem_byte_n, mem_top_oe}, 32'd2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {28'd0, mem_ce_n, mem_oe_n, rd_ready, rd_valid}, 32'he);

        for (int v = 0; v < NVEC; v++)
            do_read(VEC[v][24], VEC[v][23:0], 1'b0);

        // R2: request during a busy access is ignored
        do_read(1'b0, 24'h000100, 1'b1);
        do_read(1'b1, 24'h000777, 1'b1);

        // R8: result held across idle time while bus floats
        held = rd_data;
        repeat (20) @(negedge clk);
        chk("R8 idle hold", 32'(rd_data), 32'(held));
        chk("R2 one pulse per access", 32'(n_valid), 32'(n_reads));
        chk("R6 standby gap honoured", 32'(n_viol), 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule